// File: doc/BRIEF.md
# Eight-Source Interrupt Request Controller

This block gathers eight raw interrupt lines into one request output for a small processor bus. Each line is set on its own to capture a rising edge or to follow a level. Captured requests are held in a pending vector. Software can read the pending vector directly. A priority readout gives the number of the most urgent pending line, and reading it retires that line.

The register port is a flat, single-cycle interface. Read data is a combinational function of the address. Side effects of a read take place on the clock edge at which `rd_en` is high. Flushing through the clear register removes every captured edge request in one access. Level requests ignore every kind of clear and drop only when their input drops.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the mode register reads 0x00, the pending vector reads 0x00 and `irq_out` is low.
- R2: The mode register at address 0 is read/write. Bit n selects the mode of line n: 1 means level mode and 0 means rising-edge mode.
- R3: In edge mode, a low-to-high change on `irq_in[n]`, seen between two consecutive clock edges, sets pending bit n at the next clock edge. The bit stays set after the input falls.
- R4: In level mode, pending bit n equals `irq_in[n]` as sampled at the previous clock edge. Neither a flush nor a priority read can clear it.
- R5: Address 1 reads the pending vector, with bit n for line n. A write to any address other than 0 changes no state.
- R6: A read at address 2 returns 0x00 and clears every pending bit whose line is in edge mode.
- R7: Address 3 returns, in bits 2:0, the number of the lowest-numbered pending line, so line 0 is the most urgent. Bits 7:3 read as zero. The value is 0 when nothing is pending.
- R8: A read at address 3 clears the reported pending bit if that line is in edge mode. When nothing is pending, the read leaves the pending vector unchanged.
- R9: A rising edge captured in the same cycle as a flush or a retire of its own line wins: the bit stays pending.
- R10: `irq_out` is the OR of the pending vector, delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, applies read side effects at the clock edge |
| rdata | output | 8 | Read data for the selected register |
| irq_in | input | 8 | Raw interrupt lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong pending bit shows up at the address 1 readout at once. It also moves the priority number at address 3 in the same cycle, and `irq_out` follows one clock later. A flush or retire that reaches the wrong bits, or that reaches level-mode bits, is visible in the first pending read after that access. A lost edge in a race with a clear shows up the same way. A lost or corrupted mode bit only shows up once a line's behaviour differs between the two modes, at the next input change or clear. A direct readback of address 0 exposes it immediately.

// File: rtl/irqc_pkg.sv
// Package: shared sizes and register selects for the interrupt controller.
// Assumes the register map has four entries, decoded from a 2-bit address.
package irqc_pkg;
    localparam int unsigned SRC_N  = 8;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MODE  = 2'd0,
        SEL_PEND  = 2'd1,
        SEL_FLUSH = 2'd2,
        SEL_TOP   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irqc_mode_reg.sv
// Module: per-line mode register (1 = level, 0 = rising edge).
// Assumes the write strobe is already decoded for this register.
module irqc_mode_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] data_i,
    output logic [N-1:0] mode_o
);
    // Hold the mode bits; they reset to all-edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_o <= '0;
        else if (load_i) mode_o <= data_i;
    end
endmodule

// File: rtl/irqc_pend.sv
// Module: pending-request vector with per-line edge capture.
// Assumes irq_i is already synchronous to clk. An edge bit clears on flush_i
// or on its own retire_i bit unless a new edge arrives in the same cycle.
// A level bit copies the input and ignores every clear.
module irqc_pend #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] mode_i,
    input  logic         flush_i,
    input  logic [N-1:0] retire_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise;
        logic drop;
        assign rise = irq_i[g] & ~prev_q[g];
        assign drop = flush_i | retire_i[g];

        // Track the previous input sample and update this line's pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                pend_o[g] <= 1'b0;
            end else begin
                prev_q[g] <= irq_i[g];
                if (mode_i[g]) pend_o[g] <= irq_i[g];
                else           pend_o[g] <= rise | (pend_o[g] & ~drop);
            end
        end
    end
endmodule

// File: rtl/irqc_pick.sv
// Module: fixed-priority picker; the lowest-numbered pending line wins.
// Gives the winner's number and a one-hot select, both zero when idle.
module irqc_pick #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     sel_o
);
    // Scan from the lowest priority upwards so the lowest index wins last.
    always_comb begin
        idx_o = '0;
        sel_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o    = IDX_W'(i);
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_ctrl8.sv
// Module: eight-line interrupt controller top.
// Register map: 0 mode (rw), 1 pending (ro), 2 flush-on-read, 3 top line (read retires).
// Read data is combinational on addr; read side effects need rd_en at the clock edge.
module irq_ctrl8
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = SRC_N,
    parameter int unsigned DW    = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DW-1:0]     rdata,
    input  logic [N_SRC-1:0]  irq_in,
    output logic              irq_out
);
    localparam int unsigned IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] mode_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] top_sel;
    logic [IDX_W-1:0] top_idx;
    logic             load_mode;
    logic             do_flush;
    logic [N_SRC-1:0] do_retire;
    logic             irq_q;

    assign load_mode = wr_en && (addr == SEL_MODE);
    assign do_flush  = rd_en && (addr == SEL_FLUSH);
    assign do_retire = (rd_en && (addr == SEL_TOP)) ? top_sel : '0;

    irqc_mode_reg #(.N(N_SRC)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_mode),
        .data_i (wdata[N_SRC-1:0]),
        .mode_o (mode_q)
    );

    irqc_pend #(.N(N_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_i    (irq_in),
        .mode_i   (mode_q),
        .flush_i  (do_flush),
        .retire_i (do_retire),
        .pend_o   (pend_q)
    );

    irqc_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
        .pend_i (pend_q),
        .idx_o  (top_idx),
        .sel_o  (top_sel)
    );

    // Select read data for the addressed register.
    always_comb begin
        rdata = '0;
        unique case (addr)
            SEL_MODE:  rdata[N_SRC-1:0] = mode_q;
            SEL_PEND:  rdata[N_SRC-1:0] = pend_q;
            SEL_FLUSH: rdata = '0;
            SEL_TOP:   rdata[IDX_W-1:0] = top_idx;
            default:   rdata = '0;
        endcase
    end

    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend_q;
    end
    assign irq_out = irq_q;
endmodule

// File: rtl/irqc_checker.sv
// Module: property checker for irq_ctrl8, attached by bind below.
// Keeps its own copy of the previous input sample to recognise edges.
module irqc_checker #(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    addr,
    input logic [DW-1:0] wdata,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] rdata,
    input logic [N-1:0]  irq_in,
    input logic          irq_out,
    input logic [N-1:0]  pend,
    input logic [N-1:0]  mode
);
    localparam int unsigned IDX_W = $clog2(N);

    logic         live;
    logic [N-1:0] in_q;
    logic [N-1:0] edge_mask;
    logic [IDX_W-1:0] rd_idx;
    logic [N-1:0] below;

    // Mark cycles whose previous cycle was out of reset; keep an input copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= 1'b0;
            in_q <= '0;
        end else begin
            live <= 1'b1;
            in_q <= irq_in;
        end
    end

    assign edge_mask = irq_in & ~in_q & ~mode;
    assign rd_idx    = rdata[IDX_W-1:0];
    assign below     = ({{(N-1){1'b0}}, 1'b1} << rd_idx) - 1'b1;

    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> (mode == $past(wdata[N-1:0])));

    assert_edge_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_mask) |=> ((pend & $past(edge_mask)) == $past(edge_mask)));

    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ((pend & $past(mode)) == ($past(irq_in) & $past(mode))));

    assert_flush_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd2) |=> ((pend & ~$past(mode) & ~$past(edge_mask)) == '0));

    assert_top_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> (rdata[DW-1:IDX_W] == '0));

    assert_top_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> ((pend == '0) ? (rd_idx == '0) : (pend[rd_idx] && (pend & below) == '0)));

    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3 && pend == '0 && irq_in == '0) |=> (pend == '0));

    assert_combined_R10: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (irq_out == $past(|pend)));
endmodule

bind irq_ctrl8 irqc_checker #(.N(N_SRC), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .irq_in  (irq_in),
    .irq_out (irq_out),
    .pend    (pend_q),
    .mode    (mode_q)
);

// File: tb/sim_irq_ctrl8.sv
// Bench: directed scenarios for irq_ctrl8, one task each, 200 MHz clock.
module sim_irq_ctrl8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [7:0] irq_in = '0;
    logic       irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl8 u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Look at a register with no side effect.
    task automatic peek(logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b0;
        #1;
        d = rdata;
    endtask

    // Read with side effect: sample the data, then clock.
    task automatic rd(logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(2'd0, d); chk("R1 mode", d, 8'h00);
        peek(2'd1, d); chk("R1 pend", d, 8'h00);
        chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_mode_rw();
        logic [7:0] d;
        wr(2'd0, 8'hA5);
        peek(2'd0, d); chk("R2 readback", d, 8'hA5);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'hFF);
        peek(2'd1, d); chk("R5 write ignored pend", d, 8'h00);
        peek(2'd0, d); chk("R5 write ignored mode", d, 8'hA5);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_edge_prio();
        logic [7:0] d;
        irq_in = 8'h08;
        tick();
        peek(2'd1, d); chk("R3 captured", d, 8'h08);
        chk("R10 one stage late", {7'd0, irq_out}, 8'h00);
        irq_in = 8'h00;
        tick();
        chk("R10 high", {7'd0, irq_out}, 8'h01);
        peek(2'd1, d); chk("R3 held after fall", d, 8'h08);
        irq_in = 8'h24; tick(); irq_in = 8'h00;
        peek(2'd1, d); chk("R5 pend vector", d, 8'h2C);
        rd(2'd3, d); chk("R7 top=2", d, 8'h02);
        peek(2'd1, d); chk("R8 retire bit2", d, 8'h28);
        rd(2'd3, d); chk("R7 top=3", d, 8'h03);
        rd(2'd3, d); chk("R7 top=5", d, 8'h05);
        peek(2'd1, d); chk("R8 all retired", d, 8'h00);
        rd(2'd3, d); chk("R7 idle reads 0", d, 8'h00);
        peek(2'd1, d); chk("R8 idle read no effect", d, 8'h00);
        tick();
        chk("R10 low", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_flush_level();
        logic [7:0] d;
        wr(2'd0, 8'h02);
        irq_in = 8'hF2; tick(); irq_in = 8'h02;
        peek(2'd1, d); chk("R4 level+edges", d, 8'hF2);
        rd(2'd2, d); chk("R6 reads zero", d, 8'h00);
        peek(2'd1, d); chk("R6 edges flushed, level kept", d, 8'h02);
        rd(2'd3, d); chk("R7 top=1", d, 8'h01);
        peek(2'd1, d); chk("R4 level ignores retire", d, 8'h02);
        irq_in = 8'h00; tick();
        peek(2'd1, d); chk("R4 level drops", d, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_race();
        logic [7:0] d;
        irq_in = 8'h01; tick(); irq_in = 8'h00; tick();
        irq_in = 8'h40;
        rd(2'd2, d);
        irq_in = 8'h00;
        peek(2'd1, d); chk("R9 edge beats flush", d, 8'h40);
        tick();
        irq_in = 8'h40;
        rd(2'd3, d); chk("R7 top=6", d, 8'h06);
        irq_in = 8'h00;
        peek(2'd1, d); chk("R9 edge beats retire", d, 8'h40);
        rd(2'd2, d);
        peek(2'd1, d); chk("R6 final flush", d, 8'h00);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mode_rw();
        t_edge_prio();
        t_flush_level();
        t_race();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule